// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block sits on the 16-bit address bus of an 8-bit microcontroller and turns each address into at most one memory select. It serves four main Flash sectors, two EEPROM sectors, one SRAM region and two I/O windows: one for general I/O and one for peripheral I/O. Each region is described by a programmable match term, which is a base value, a care mask and an enable bit. The SRAM region is the OR of two such terms. Regions may overlap. Any overlap is settled by a fixed three-level ranking. The SRAM and both I/O windows share the top level. The EEPROM sectors sit in the middle level. The Flash sectors sit at the bottom.

The selects are combinational from the address and from the memory-request input. The match terms live in registers, which are written through a plain address/data/write-enable port. When no region claims an address, an `unmapped` flag is raised instead of a select. When two regions on the winning level both claim it, an `overlap_err` flag is raised and no select is driven. On an SRAM hit the low eleven address bits are passed out as the offset into the 2K x 8 array.

Top module: `chip_sel_decoder`

## Requirements
- R1: After reset every match term is disabled, so with `mem_req` high every address gives all selects low and `unmapped` high.
- R2: A term hits when its enable is set and `(addr ^ base) & mask == 0`. The write port takes `cfg_addr = {term[3:0], field[1:0]}`. Field 0 is the base, field 1 is the mask and field 2 is the enable, held in `cfg_wdata[0]`. Terms 0-3 are Flash sectors 0-3, terms 4-5 are EEPROM sectors 0-1, terms 6-7 are the two SRAM terms, term 8 is general I/O and term 9 is peripheral I/O. A write to field 3, or to a term index above 9, changes nothing.
- R3: While `mem_req` is low, every select, `unmapped` and `overlap_err` are low.
- R4: A hit in the top level (SRAM, I/O or peripheral I/O) suppresses every EEPROM and Flash select.
- R5: An EEPROM hit with no top-level hit suppresses every Flash select.
- R6: The SRAM select is the OR of its two terms. Both SRAM terms hitting together counts as a single region and raises no error.
- R7: `sram_offset` equals `addr[10:0]` while `sram_sel` is high, and is zero otherwise.
- R8: If two regions on the highest level that has any hit both hit, `overlap_err` is high and all selects are low.
- R9: With `mem_req` high and no hit on any level, `unmapped` is high and all selects are low.
- R10: At most one select is high at any time.
- R11: With Flash 0 at 8000h-BFFFh, EEPROM 0 at 8000h-9FFFh and SRAM at 8000h-87FFh, the decoder behaves as follows. Address 8400h selects SRAM, 9000h selects EEPROM 0 and A000h selects Flash 0. No address in 8000h-9FFFh selects Flash 0.
- R12: The outputs follow `addr` and `mem_req` within the same cycle. A configuration write takes effect from the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Term index (bits 5:2) and field (bits 1:0) |
| cfg_wdata | input | 16 | Configuration write data |
| mem_req | input | 1 | Bus memory request; gates all outputs |
| addr | input | 16 | Bus address |
| flash_sel | output | 4 | Flash sector selects |
| ee_sel | output | 2 | EEPROM sector selects |
| sram_sel | output | 1 | SRAM select, active high |
| io_sel | output | 1 | General I/O window select |
| pio_sel | output | 1 | Peripheral I/O window select |
| sram_offset | output | 11 | Array offset on an SRAM hit |
| unmapped | output | 1 | No region matches the address |
| overlap_err | output | 1 | Two regions on the winning level both match |

## Verification
The bench first tries the three-way nested overlap from the worked configuration. Addresses are picked inside the SRAM window, in the EEPROM-only band and in the Flash-only band, which separates the priority paths of all three levels. Further directed cases cover the following: both SRAM terms hitting together against two different levels colliding, a same-level collision in the top and middle levels, and writes to unused fields and term indices. A final phase sweeps random addresses and request values against a behavioural model. That phase exposes mask, gating and offset errors that the fixed points could miss.

// File: rtl/cs_decode_pkg.sv
package cs_decode_pkg;

    localparam int ADDR_W     = 16;
    localparam int SRAM_OFF_W = 11;
    localparam int FIELD_W    = 2;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
    } term_t;

    typedef enum logic [FIELD_W-1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_EN   = 2'd2
    } field_e;

    function automatic logic term_hit(input term_t t, input logic [ADDR_W-1:0] a);
        return t.en && (((a ^ t.base) & t.mask) == '0);
    endfunction

endpackage

// File: rtl/cs_term_regs.sv
module cs_term_regs
    import cs_decode_pkg::*;
#(
    parameter int N_TERMS = 10,
    parameter int IDX_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [IDX_W+FIELD_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0]        cfg_wdata,
    output term_t [N_TERMS-1:0]      terms
);

    logic [IDX_W-1:0] wr_idx;
    field_e           wr_fld;

    assign wr_idx = cfg_addr[IDX_W+FIELD_W-1:FIELD_W];
    assign wr_fld = field_e'(cfg_addr[FIELD_W-1:0]);

    for (genvar i = 0; i < N_TERMS; i++) begin : g_term
        logic sel_here;
        assign sel_here = cfg_we && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                terms[i] <= '0;
            end else if (sel_here) begin
                case (wr_fld)
                    FLD_BASE: terms[i].base <= cfg_wdata;
                    FLD_MASK: terms[i].mask <= cfg_wdata;
                    FLD_EN:   terms[i].en   <= cfg_wdata[0];
                    default:  ;
                endcase
            end
        end

        assert_reset_clears_R1: assert property (@(posedge clk)
            rst |=> !terms[i].en);

        assert_enable_write_R2: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_addr == {IDX_W'(i), FLD_EN}) |=> (terms[i].en == $past(cfg_wdata[0])));

        assert_field3_ignored_R2: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_addr[FIELD_W-1:0] == 2'd3) |=> $stable(terms[i]));
    end

endmodule

// File: rtl/cs_match.sv
module cs_match
    import cs_decode_pkg::*;
#(
    parameter int N_TERMS = 10
) (
    input  term_t [N_TERMS-1:0] terms,
    input  logic  [ADDR_W-1:0]  addr,
    output logic  [N_TERMS-1:0] hit
);

    for (genvar i = 0; i < N_TERMS; i++) begin : g_cmp
        assign hit[i] = term_hit(terms[i], addr);
    end

endmodule

// File: rtl/cs_resolve.sv
module cs_resolve
    import cs_decode_pkg::*;
#(
    parameter int N_FLASH      = 4,
    parameter int N_EE         = 2,
    parameter int N_SRAM_TERMS = 2,
    localparam int EE_BASE     = N_FLASH,
    localparam int SRAM_BASE   = EE_BASE + N_EE,
    localparam int IO_IDX      = SRAM_BASE + N_SRAM_TERMS,
    localparam int PIO_IDX     = IO_IDX + 1,
    localparam int N_TERMS     = PIO_IDX + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_TERMS-1:0]    hit,
    input  logic                  mem_req,
    input  logic [ADDR_W-1:0]     addr,
    output logic [N_FLASH-1:0]    flash_sel,
    output logic [N_EE-1:0]       ee_sel,
    output logic                  sram_sel,
    output logic                  io_sel,
    output logic                  pio_sel,
    output logic [SRAM_OFF_W-1:0] sram_offset,
    output logic                  unmapped,
    output logic                  overlap_err
);

    logic [2:0]         top_v;
    logic [N_EE-1:0]    mid_v;
    logic [N_FLASH-1:0] low_v;
    logic               top_multi, mid_multi, low_multi;

    assign top_v = {hit[PIO_IDX], hit[IO_IDX], |hit[SRAM_BASE +: N_SRAM_TERMS]};
    assign mid_v = hit[EE_BASE +: N_EE];
    assign low_v = hit[0 +: N_FLASH];

    assign top_multi = (top_v & (top_v - 3'd1)) != '0;
    assign mid_multi = (mid_v & (mid_v - 1'b1)) != '0;
    assign low_multi = (low_v & (low_v - 1'b1)) != '0;

    always_comb begin
        flash_sel   = '0;
        ee_sel      = '0;
        sram_sel    = 1'b0;
        io_sel      = 1'b0;
        pio_sel     = 1'b0;
        sram_offset = '0;
        unmapped    = 1'b0;
        overlap_err = 1'b0;
        if (mem_req) begin
            if (|top_v) begin
                if (top_multi) begin
                    overlap_err = 1'b1;
                end else begin
                    sram_sel = top_v[0];
                    io_sel   = top_v[1];
                    pio_sel  = top_v[2];
                    if (top_v[0]) sram_offset = addr[SRAM_OFF_W-1:0];
                end
            end else if (|mid_v) begin
                if (mid_multi) overlap_err = 1'b1;
                else           ee_sel      = mid_v;
            end else if (|low_v) begin
                if (low_multi) overlap_err = 1'b1;
                else           flash_sel   = low_v;
            end else begin
                unmapped = 1'b1;
            end
        end
    end

    assert_one_select_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flash_sel, ee_sel, sram_sel, io_sel, pio_sel}));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> ({flash_sel, ee_sel, sram_sel, io_sel, pio_sel, unmapped, overlap_err} == '0));

    assert_top_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && |top_v) |-> ({flash_sel, ee_sel} == '0));

    assert_mid_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && |mid_v) |-> (flash_sel == '0));

    assert_err_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        overlap_err |-> ({flash_sel, ee_sel, sram_sel, io_sel, pio_sel} == '0));

    assert_unmapped_no_hit_R9: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (hit == '0 && !overlap_err));

endmodule

// File: rtl/chip_sel_decoder.sv
module chip_sel_decoder
    import cs_decode_pkg::*;
#(
    parameter int N_FLASH      = 4,
    parameter int N_EE         = 2,
    parameter int N_SRAM_TERMS = 2,
    localparam int N_TERMS     = N_FLASH + N_EE + N_SRAM_TERMS + 2,
    localparam int IDX_W       = $clog2(N_TERMS),
    localparam int CFG_AW      = IDX_W + FIELD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    input  logic                  mem_req,
    input  logic [ADDR_W-1:0]     addr,
    output logic [N_FLASH-1:0]    flash_sel,
    output logic [N_EE-1:0]       ee_sel,
    output logic                  sram_sel,
    output logic                  io_sel,
    output logic                  pio_sel,
    output logic [SRAM_OFF_W-1:0] sram_offset,
    output logic                  unmapped,
    output logic                  overlap_err
);

    term_t [N_TERMS-1:0] terms;
    logic  [N_TERMS-1:0] hit;

    cs_term_regs #(.N_TERMS(N_TERMS), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .terms     (terms)
    );

    cs_match #(.N_TERMS(N_TERMS)) u_match (
        .terms (terms),
        .addr  (addr),
        .hit   (hit)
    );

    cs_resolve #(
        .N_FLASH      (N_FLASH),
        .N_EE         (N_EE),
        .N_SRAM_TERMS (N_SRAM_TERMS)
    ) u_resolve (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit),
        .mem_req     (mem_req),
        .addr        (addr),
        .flash_sel   (flash_sel),
        .ee_sel      (ee_sel),
        .sram_sel    (sram_sel),
        .io_sel      (io_sel),
        .pio_sel     (pio_sel),
        .sram_offset (sram_offset),
        .unmapped    (unmapped),
        .overlap_err (overlap_err)
    );

endmodule

// File: tb/sim_chip_sel_decoder.sv
`timescale 1ns/1ps
module sim_chip_sel_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        mem_req = 1'b0;
    logic [15:0] addr = '0;
    logic [3:0]  flash_sel;
    logic [1:0]  ee_sel;
    logic        sram_sel, io_sel, pio_sel, unmapped, overlap_err;
    logic [10:0] sram_offset;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    chip_sel_decoder u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .addr(addr),
        .flash_sel(flash_sel), .ee_sel(ee_sel), .sram_sel(sram_sel),
        .io_sel(io_sel), .pio_sel(pio_sel), .sram_offset(sram_offset),
        .unmapped(unmapped), .overlap_err(overlap_err)
    );

    // Behavioural reference: a table of terms updated on writes
    bit          m_en[10];
    logic [15:0] m_base[10];
    logic [15:0] m_mask[10];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 10; i++) begin
                m_en[i] <= 1'b0; m_base[i] <= '0; m_mask[i] <= '0;
            end
        end else if (cfg_we && cfg_addr[5:2] < 4'd10) begin
            case (cfg_addr[1:0])
                2'd0: m_base[cfg_addr[5:2]] <= cfg_wdata;
                2'd1: m_mask[cfg_addr[5:2]] <= cfg_wdata;
                2'd2: m_en[cfg_addr[5:2]]   <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    function automatic logic [21:0] pack(logic [3:0] f, logic [1:0] e, logic s, logic io,
                                         logic pio, logic [10:0] off, logic un, logic er);
        return {f, e, s, io, pio, off, un, er};
    endfunction

    function automatic logic [21:0] model(logic req, logic [15:0] a);
        int n_top = 0, n_mid = 0, n_low = 0;
        int which_top = -1, which_mid = -1, which_low = -1;
        bit h[10];
        for (int i = 0; i < 10; i++) h[i] = m_en[i] && (((a ^ m_base[i]) & m_mask[i]) == 16'h0);
        if (!req) return '0;
        if (h[6] || h[7]) begin n_top++; which_top = 0; end
        if (h[8]) begin n_top++; which_top = 1; end
        if (h[9]) begin n_top++; which_top = 2; end
        for (int i = 0; i < 2; i++) if (h[4+i]) begin n_mid++; which_mid = i; end
        for (int i = 0; i < 4; i++) if (h[i]) begin n_low++; which_low = i; end
        if (n_top > 1) return pack(0, 0, 0, 0, 0, 0, 0, 1);
        if (n_top == 1) begin
            if (which_top == 0) return pack(0, 0, 1, 0, 0, a[10:0], 0, 0);
            if (which_top == 1) return pack(0, 0, 0, 1, 0, 0, 0, 0);
            return pack(0, 0, 0, 0, 1, 0, 0, 0);
        end
        if (n_mid > 1) return pack(0, 0, 0, 0, 0, 0, 0, 1);
        if (n_mid == 1) return pack(0, 2'(1 << which_mid), 0, 0, 0, 0, 0, 0);
        if (n_low > 1) return pack(0, 0, 0, 0, 0, 0, 0, 1);
        if (n_low == 1) return pack(4'(1 << which_low), 0, 0, 0, 0, 0, 0, 0);
        return pack(0, 0, 0, 0, 0, 0, 1, 0);
    endfunction

    function automatic logic [21:0] actual();
        return {flash_sel, ee_sel, sram_sel, io_sel, pio_sel, sram_offset, unmapped, overlap_err};
    endfunction

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (actual() !== model(mem_req, addr)) begin
                fails++;
                $display("FAIL %s model addr=%h actual=%h expected=%h", cur_req, addr,
                         actual(), model(mem_req, addr));
            end
        end
    end

    task automatic expect_out(string req, logic [21:0] exp);
        @(negedge clk);
        #1;
        checks++;
        if (actual() !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, actual(), exp);
        end
    endtask

    task automatic drive(logic req, logic [15:0] a);
        @(posedge clk);
        #1;
        mem_req = req;
        addr = a;
    endtask

    task automatic wr(int idx, int fld, logic [15:0] d);
        @(posedge clk);
        #1;
        cfg_we = 1'b1;
        cfg_addr = {4'(idx), 2'(fld)};
        cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_term(int idx, logic [15:0] b, logic [15:0] m, bit en);
        wr(idx, 0, b);
        wr(idx, 1, m);
        wr(idx, 2, {15'd0, en});
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        cur_req = "R1";
        drive(1, 16'h8400);
        expect_out("R1", pack(0, 0, 0, 0, 0, 0, 1, 0));

        // Worked nested configuration
        cur_req = "R11";
        set_term(0, 16'h8000, 16'hC000, 1);
        set_term(4, 16'h8000, 16'hE000, 1);
        set_term(6, 16'h8000, 16'hF800, 1);
        drive(1, 16'h8400);
        expect_out("R11/R4/R7", pack(0, 0, 1, 0, 0, 11'h400, 0, 0));
        drive(1, 16'h9000);
        expect_out("R11/R5", pack(0, 2'b01, 0, 0, 0, 0, 0, 0));
        drive(1, 16'hA000);
        expect_out("R11", pack(4'b0001, 0, 0, 0, 0, 0, 0, 0));
        for (int a = 16'h8000; a <= 16'h9FFF; a += 16'h0100) begin
            drive(1, 16'(a));
            @(negedge clk);
            #1;
            checks++;
            if (flash_sel[0] !== 1'b0) begin
                fails++;
                $display("FAIL R11 addr=%h flash_sel=%b expected=0000", 16'(a), flash_sel);
            end
        end
        drive(1, 16'hC000);
        expect_out("R9", pack(0, 0, 0, 0, 0, 0, 1, 0));

        cur_req = "R3";
        drive(0, 16'h8400);
        expect_out("R3", '0);
        drive(0, 16'hC000);
        expect_out("R3", '0);

        // Both SRAM terms hit together: single region
        cur_req = "R6";
        set_term(7, 16'h8000, 16'hFC00, 1);
        drive(1, 16'h8123);
        expect_out("R6/R7", pack(0, 0, 1, 0, 0, 11'h123, 0, 0));

        // Write timing: old mapping before the edge, new after
        cur_req = "R12";
        wr(7, 1, 16'hF800);
        wr(7, 0, 16'hF000);
        drive(1, 16'hF012);
        expect_out("R12", pack(0, 0, 1, 0, 0, 11'h012, 0, 0));
        @(posedge clk);
        #1;
        cfg_we = 1'b1; cfg_addr = {4'd7, 2'd2}; cfg_wdata = 16'h0000;
        @(negedge clk);
        #1;
        checks++;
        if (sram_sel !== 1'b1) begin
            fails++;
            $display("FAIL R12 before edge sram_sel=%b expected=1", sram_sel);
        end
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        expect_out("R12", pack(0, 0, 0, 0, 0, 0, 1, 0));

        // Ignored writes
        cur_req = "R2";
        wr(6, 3, 16'h0000);
        wr(12, 2, 16'h0001);
        drive(1, 16'h8400);
        expect_out("R2", pack(0, 0, 1, 0, 0, 11'h400, 0, 0));
        set_term(3, 16'h0000, 16'h0000, 1);
        drive(1, 16'hC000);
        expect_out("R2", pack(4'b1000, 0, 0, 0, 0, 0, 0, 0));
        drive(1, 16'hA000);
        expect_out("R8", pack(0, 0, 0, 0, 0, 0, 0, 1));
        wr(3, 2, 16'h0000);

        // Same-level collisions
        cur_req = "R8";
        set_term(8, 16'h8000, 16'hF800, 1);
        drive(1, 16'h8400);
        expect_out("R8", pack(0, 0, 0, 0, 0, 0, 0, 1));
        wr(8, 2, 16'h0000);
        set_term(5, 16'h9000, 16'hF000, 1);
        drive(1, 16'h9000);
        expect_out("R8", pack(0, 0, 0, 0, 0, 0, 0, 1));
        drive(1, 16'h8400);
        expect_out("R4", pack(0, 0, 1, 0, 0, 11'h400, 0, 0));

        // I/O windows
        cur_req = "R4";
        set_term(8, 16'hE000, 16'hFF00, 1);
        set_term(9, 16'hE100, 16'hFF00, 1);
        set_term(2, 16'hE000, 16'hE000, 1);
        drive(1, 16'hE055);
        expect_out("R4", pack(0, 0, 0, 1, 0, 0, 0, 0));
        drive(1, 16'hE1AA);
        expect_out("R4", pack(0, 0, 0, 0, 1, 0, 0, 0));
        drive(1, 16'hE200);
        expect_out("R5", pack(4'b0100, 0, 0, 0, 0, 0, 0, 0));

        // Random sweep against the model
        cur_req = "R10";
        for (int k = 0; k < 400; k++) begin
            drive(($urandom % 8) != 0, 16'($urandom));
        end

        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule